// File: doc/BRIEF.md
# Multiplier Result Port Router

This block sits at the output of a SIMD integer multiply unit. It places each result on one of four fixed write-back ports at a latency set by the chunk size of the operation. An issue command gives an opcode, a chunk-size code and a destination tag. The block carries these through a tag pipeline. When the operation's latency has elapsed, each port's 4:1 multiplexer picks the datapath tap for the right chunk size, and the block raises that port's valid and tag.

The arithmetic array is not part of this block. Its results arrive as four tap groups: low part, high part, low accumulate and high accumulate. Each group has one 64-bit tap per chunk size. Each opcode family always uses the same port, so the write-back crossbar never has to arbitrate between multiplier results. There is one case the fixed latencies cannot prevent: a long-latency operation and a later short-latency operation finish in the same cycle on the same port. The block reports this on a per-port collision output and does not drop it silently.

The block has no state machine. Its only state is the tag pipeline, one register stage per cycle of the longest latency. Each stage holds a valid bit, an opcode, a chunk-size code and a tag.

Top module: `mrr_port_router`

## Requirements
- R1: Chunk-size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. An operation sampled at a clock edge appears on its ports in the 4th, 5th, 5th or 6th cycle after that edge, respectively, and only in that cycle.
- R2: Opcode 0 (mul) and opcode 1 (amac) drive port 0 only, carrying the low-part tap of the operation's chunk size. Ports 1 to 3 stay idle for them.
- R3: Opcode 2 (mulh) drives port 0 with the low-part tap and port 1 with the high-part tap in the same cycle. Both ports carry the same tag.
- R4: Opcode 3 (macl) drives port 2 with the low-accumulate tap. Opcode 4 (mach) drives port 3 with the high-accumulate tap.
- R5: A port holds valid high for exactly one cycle per operation it carries, and its tag output equals the tag given at issue.
- R6: When the external-select enable is high, port p's multiplexer takes its select from bits [2p+1:2p] of the external select input and not from the operation's chunk size.
- R7: When two operations in flight finish on the same port in the same cycle, that port's collision output is high for that cycle. The port carries the older operation (the one with the longer latency).
- R8: A synchronous reset clears every operation in flight. No port raises valid in the cycles after a reset edge unless an operation is issued after the reset.
- R9: Issues with opcodes 5, 6 or 7 are dropped and never raise any port's valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Issue command present this cycle |
| issue_op | input | 3 | Opcode: 0 mul, 1 amac, 2 mulh, 3 macl, 4 mach |
| issue_size | input | 2 | Chunk-size code 0..3 (8/16/32/64-bit) |
| issue_tag | input | TAG_W | Destination tag carried to the ports |
| ext_sel_en | input | 1 | Use the external multiplexer selects |
| ext_sel | input | 2*NPORT | External select, 2 bits per port |
| lo_tap | input | NSIZE*DATA_W | Low-part taps, one per chunk size |
| hi_tap | input | NSIZE*DATA_W | High-part taps, one per chunk size |
| macl_tap | input | NSIZE*DATA_W | Low accumulate taps, one per chunk size |
| mach_tap | input | NSIZE*DATA_W | High accumulate taps, one per chunk size |
| port_valid | output | NPORT | Per-port result valid |
| port_tag | output | NPORT*TAG_W | Per-port destination tag |
| port_data | output | NPORT*DATA_W | Per-port result data |
| port_collide | output | NPORT | Per-port same-cycle collision flag |

## Verification
The bench sweeps every opcode against every chunk size and checks all four ports in every cycle up to the drain point. A design with an off-by-one latency, or one that shares a latency wrongly between the 16-bit and 32-bit sizes, shows valid in the wrong cycle. A design that misroutes amac or mulh shows data on the wrong port. To exercise the collision path, a 64-bit operation is issued and an 8-bit operation follows two cycles later, so both land together. A design that lets the younger operation win puts the wrong tag and data on the port, and one without detection leaves the collision flag low. The bench also tests these cases: two operations landing together on different ports, which must not be flagged; a reset while an operation is in flight, which must leave no late valid; opcodes 5 to 7, which must be dropped; and external selects, which must override the chunk size.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_AMAC = 3'd1,
        OP_MULH = 3'd2,
        OP_MACL = 3'd3,
        OP_MACH = 3'd4
    } mrr_op_e;

    localparam int unsigned NPORT  = 4;
    localparam int unsigned NSIZE  = 4;
    localparam int unsigned SIZE_W = 2;
    localparam int unsigned OP_W   = 3;

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return op <= OP_MACH;
    endfunction

    // Fixed opcode-to-port map; port 0 is the low part, port 1 the high part.
    function automatic logic op_hits_port(input logic [OP_W-1:0] op, input int unsigned port);
        logic r;
        unique case (port)
            0:       r = (op == OP_MUL) || (op == OP_AMAC) || (op == OP_MULH);
            1:       r = (op == OP_MULH);
            2:       r = (op == OP_MACL);
            3:       r = (op == OP_MACH);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mrr_tag_pipe.sv
module mrr_tag_pipe
    import mrr_pkg::*;
#(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned TAG_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic [OP_W-1:0]      in_op,
    input  logic [SIZE_W-1:0]    in_size,
    input  logic [TAG_W-1:0]     in_tag,
    output logic                 st_vld  [DEPTH],
    output logic [OP_W-1:0]      st_op   [DEPTH],
    output logic [SIZE_W-1:0]    st_size [DEPTH],
    output logic [TAG_W-1:0]     st_tag  [DEPTH]
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic              nx_vld;
        logic [OP_W-1:0]   nx_op;
        logic [SIZE_W-1:0] nx_size;
        logic [TAG_W-1:0]  nx_tag;

        if (g == 0) begin : g_head
            assign nx_vld  = in_vld;
            assign nx_op   = in_op;
            assign nx_size = in_size;
            assign nx_tag  = in_tag;
        end else begin : g_body
            assign nx_vld  = st_vld[g-1];
            assign nx_op   = st_op[g-1];
            assign nx_size = st_size[g-1];
            assign nx_tag  = st_tag[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_vld[g] <= 1'b0;
            end else begin
                st_vld[g] <= nx_vld;
            end
        end

        always_ff @(posedge clk) begin
            st_op[g]   <= nx_op;
            st_size[g] <= nx_size;
            st_tag[g]  <= nx_tag;
        end
    end

endmodule

// File: rtl/mrr_port_pick.sv
module mrr_port_pick
    import mrr_pkg::*;
#(
    parameter int unsigned PORT_ID = 0,
    parameter int unsigned DEPTH   = 6,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned LAT_B   = 4,
    parameter int unsigned LAT_H   = 5,
    parameter int unsigned LAT_W   = 5,
    parameter int unsigned LAT_D   = 6
) (
    input  logic                 st_vld  [DEPTH],
    input  logic [OP_W-1:0]      st_op   [DEPTH],
    input  logic [SIZE_W-1:0]    st_size [DEPTH],
    input  logic [TAG_W-1:0]     st_tag  [DEPTH],
    output logic                 hit,
    output logic                 collide,
    output logic [SIZE_W-1:0]    win_size,
    output logic [TAG_W-1:0]     win_tag
);

    logic [DEPTH-1:0] lands;

    function automatic int unsigned lat_of(input logic [SIZE_W-1:0] s);
        int unsigned r;
        unique case (s)
            2'd0:    r = LAT_B;
            2'd1:    r = LAT_H;
            2'd2:    r = LAT_W;
            default: r = LAT_D;
        endcase
        return r;
    endfunction

    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            lands[s] = st_vld[s] && (lat_of(st_size[s]) == s + 1)
                       && op_hits_port(st_op[s], PORT_ID);
        end
    end

    // Ascending scan: the last match is the deepest stage, i.e. the oldest operation.
    always_comb begin
        win_size = '0;
        win_tag  = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (lands[s]) begin
                win_size = st_size[s];
                win_tag  = st_tag[s];
            end
        end
    end

    assign hit     = |lands;
    assign collide = $countones(lands) > 1;

endmodule

// File: rtl/mrr_tap_mux.sv
module mrr_tap_mux
    import mrr_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [NSIZE*DATA_W-1:0] taps,
    input  logic [SIZE_W-1:0]       sel,
    output logic [DATA_W-1:0]       dout
);

    always_comb begin
        dout = '0;
        for (int i = 0; i < NSIZE; i++) begin
            if (sel == SIZE_W'(i)) begin
                dout = taps[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/mrr_port_router.sv
module mrr_port_router
    import mrr_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned LAT_B  = 4,
    parameter int unsigned LAT_H  = 5,
    parameter int unsigned LAT_W  = 5,
    parameter int unsigned LAT_D  = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      issue_valid,
    input  logic [2:0]                issue_op,
    input  logic [1:0]                issue_size,
    input  logic [TAG_W-1:0]          issue_tag,
    input  logic                      ext_sel_en,
    input  logic [2*4-1:0]            ext_sel,
    input  logic [4*DATA_W-1:0]       lo_tap,
    input  logic [4*DATA_W-1:0]       hi_tap,
    input  logic [4*DATA_W-1:0]       macl_tap,
    input  logic [4*DATA_W-1:0]       mach_tap,
    output logic [3:0]                port_valid,
    output logic [4*TAG_W-1:0]        port_tag,
    output logic [4*DATA_W-1:0]       port_data,
    output logic [3:0]                port_collide
);

    localparam int unsigned LAT_BH = (LAT_B > LAT_H) ? LAT_B : LAT_H;
    localparam int unsigned LAT_WD = (LAT_W > LAT_D) ? LAT_W : LAT_D;
    localparam int unsigned DEPTH  = (LAT_BH > LAT_WD) ? LAT_BH : LAT_WD;

    logic              st_vld  [DEPTH];
    logic [OP_W-1:0]   st_op   [DEPTH];
    logic [SIZE_W-1:0] st_size [DEPTH];
    logic [TAG_W-1:0]  st_tag  [DEPTH];

    mrr_tag_pipe #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W)
    ) pipe_i (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (issue_valid && op_known(issue_op)),
        .in_op   (issue_op),
        .in_size (issue_size),
        .in_tag  (issue_tag),
        .st_vld  (st_vld),
        .st_op   (st_op),
        .st_size (st_size),
        .st_tag  (st_tag)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [NSIZE*DATA_W-1:0] taps;
        logic [SIZE_W-1:0]       win_size;
        logic [SIZE_W-1:0]       sel;

        if (p == 0) begin : g_lo
            assign taps = lo_tap;
        end else if (p == 1) begin : g_hi
            assign taps = hi_tap;
        end else if (p == 2) begin : g_acl
            assign taps = macl_tap;
        end else begin : g_ach
            assign taps = mach_tap;
        end

        mrr_port_pick #(
            .PORT_ID (p),
            .DEPTH   (DEPTH),
            .TAG_W   (TAG_W),
            .LAT_B   (LAT_B),
            .LAT_H   (LAT_H),
            .LAT_W   (LAT_W),
            .LAT_D   (LAT_D)
        ) pick_i (
            .st_vld   (st_vld),
            .st_op    (st_op),
            .st_size  (st_size),
            .st_tag   (st_tag),
            .hit      (port_valid[p]),
            .collide  (port_collide[p]),
            .win_size (win_size),
            .win_tag  (port_tag[p*TAG_W +: TAG_W])
        );

        assign sel = ext_sel_en ? ext_sel[p*SIZE_W +: SIZE_W] : win_size;

        mrr_tap_mux #(
            .DATA_W (DATA_W)
        ) mux_i (
            .taps (taps),
            .sel  (sel),
            .dout (port_data[p*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/mrr_port_router_chk.sv
module mrr_port_router_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned LAT_B  = 4,
    parameter int unsigned LAT_D  = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 issue_valid,
    input logic [2:0]           issue_op,
    input logic [1:0]           issue_size,
    input logic                 ext_sel_en,
    input logic [7:0]           ext_sel,
    input logic [4*DATA_W-1:0]  lo_tap,
    input logic [3:0]           port_valid,
    input logic [4*TAG_W-1:0]   port_tag,
    input logic [4*DATA_W-1:0]  port_data,
    input logic [3:0]           port_collide
);

    a_r3_mulh_pair: assert property (@(posedge clk) disable iff (rst)
        port_valid[1] |-> port_valid[0]);

    a_r3_same_tag: assert property (@(posedge clk) disable iff (rst)
        (port_valid[1] && !port_collide[0]) |->
            (port_tag[TAG_W-1:0] == port_tag[TAG_W +: TAG_W]));

    a_r7_collide_valid: assert property (@(posedge clk) disable iff (rst)
        (port_collide & ~port_valid) == 4'b0);

    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (port_valid == 4'b0));

    a_r6_ext_select: assert property (@(posedge clk) disable iff (rst)
        (ext_sel_en && port_valid[0]) |->
            (port_data[DATA_W-1:0] == lo_tap[ext_sel[1:0]*DATA_W +: DATA_W]));

    if (LAT_B == 4) begin : g_lat_b
        a_r1_lat_byte: assert property (@(posedge clk) disable iff (rst)
            (issue_valid && issue_op == 3'd0 && issue_size == 2'd0) |-> ##4 port_valid[0]);
    end

    if (LAT_D == 6) begin : g_lat_d
        a_r1_lat_dword: assert property (@(posedge clk) disable iff (rst)
            (issue_valid && issue_op == 3'd4 && issue_size == 2'd3) |-> ##6 port_valid[3]);
    end

endmodule

bind mrr_port_router mrr_port_router_chk #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .LAT_B  (LAT_B),
    .LAT_D  (LAT_D)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .issue_valid  (issue_valid),
    .issue_op     (issue_op),
    .issue_size   (issue_size),
    .ext_sel_en   (ext_sel_en),
    .ext_sel      (ext_sel),
    .lo_tap       (lo_tap),
    .port_valid   (port_valid),
    .port_tag     (port_tag),
    .port_data    (port_data),
    .port_collide (port_collide)
);

// File: tb/mrr_port_router_tb_top.sv
module mrr_port_router_tb_top;

    localparam int DW = 64;
    localparam int TW = 6;

    logic            clk = 1'b0;
    logic            rst;
    logic            issue_valid;
    logic [2:0]      issue_op;
    logic [1:0]      issue_size;
    logic [TW-1:0]   issue_tag;
    logic            ext_sel_en;
    logic [7:0]      ext_sel;
    logic [4*DW-1:0] lo_tap, hi_tap, macl_tap, mach_tap;
    logic [3:0]      port_valid;
    logic [4*TW-1:0] port_tag;
    logic [4*DW-1:0] port_data;
    logic [3:0]      port_collide;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    mrr_port_router dut_i (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_size(issue_size), .issue_tag(issue_tag), .ext_sel_en(ext_sel_en),
        .ext_sel(ext_sel), .lo_tap(lo_tap), .hi_tap(hi_tap), .macl_tap(macl_tap),
        .mach_tap(mach_tap), .port_valid(port_valid), .port_tag(port_tag),
        .port_data(port_data), .port_collide(port_collide)
    );

    function automatic logic [63:0] tap_val(input int kind, input int sz);
        return 64'h0101_0101_0101_0101 * 64'(kind * 4 + sz + 1);
    endfunction

    function automatic int lat_of(input int sz);
        return (sz == 0) ? 4 : (sz == 3) ? 6 : 5;
    endfunction

    function automatic bit targets(input int op, input int p);
        case (p)
            0: return op == 0 || op == 1 || op == 2;
            1: return op == 2;
            2: return op == 3;
            3: return op == 4;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_ports(input logic [3:0] ev, input string req);
        check(port_valid == ev, req, "port_valid", 64'(port_valid), 64'(ev));
    endtask

    task automatic run_one(input int op, input int sz, input logic [TW-1:0] tg);
        @(negedge clk);
        issue_valid = 1; issue_op = 3'(op); issue_size = 2'(sz); issue_tag = tg;
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) issue_valid = 0;
            for (int p = 0; p < 4; p++) begin
                bit ev;
                ev = (k == lat_of(sz)) && targets(op, p);
                // R1 latency, R2/R3/R4 port map
                check(port_valid[p] == ev, "R1/R2/R3/R4", $sformatf("valid op%0d sz%0d k%0d p%0d", op, sz, k, p),
                      64'(port_valid[p]), 64'(ev));
                if (ev) begin
                    check(port_data[p*DW +: DW] == tap_val(p, sz), "R2_R3_R4 data",
                          $sformatf("op%0d sz%0d p%0d", op, sz, p), port_data[p*DW +: DW], tap_val(p, sz));
                    check(port_tag[p*TW +: TW] == tg, "R5 tag", $sformatf("op%0d p%0d", op, p),
                          64'(port_tag[p*TW +: TW]), 64'(tg));
                end
            end
            check(port_collide == 0, "R7 no-collide", "single op", 64'(port_collide), 0);
        end
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            lo_tap[k*DW +: DW]   = tap_val(0, k);
            hi_tap[k*DW +: DW]   = tap_val(1, k);
            macl_tap[k*DW +: DW] = tap_val(2, k);
            mach_tap[k*DW +: DW] = tap_val(3, k);
        end
        rst = 1; issue_valid = 0; issue_op = 0; issue_size = 0; issue_tag = 0;
        ext_sel_en = 0; ext_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_ports(4'b0, "R8 reset state");
        check(port_collide == 0, "R8", "reset collide", 64'(port_collide), 0);
        rst = 0;

        // R1 R2 R3 R4 R5: full sweep of opcode by chunk size
        for (int op = 0; op < 5; op++)
            for (int sz = 0; sz < 4; sz++)
                run_one(op, sz, TW'(op * 4 + sz + 3));

        // R9: unknown opcodes dropped
        for (int op = 5; op < 8; op++) begin
            @(negedge clk);
            issue_valid = 1; issue_op = 3'(op); issue_size = 2'd0; issue_tag = 6'h11;
            for (int k = 1; k <= 7; k++) begin
                @(posedge clk); @(negedge clk);
                issue_valid = 0;
                check_ports(4'b0, "R9 unknown opcode");
            end
        end

        // R7: 64-bit mul then 8-bit mul two cycles later land together on port 0
        @(negedge clk);
        issue_valid = 1; issue_op = 3'd0; issue_size = 2'd3; issue_tag = 6'h2A;
        @(posedge clk); @(negedge clk); issue_valid = 0;
        @(posedge clk); @(negedge clk);
        issue_valid = 1; issue_op = 3'd1; issue_size = 2'd0; issue_tag = 6'h15;
        @(posedge clk); @(negedge clk); issue_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_ports(4'b0001, "R7 collide valid");
        check(port_collide == 4'b0001, "R7", "collide flag", 64'(port_collide), 64'h1);
        check(port_tag[TW-1:0] == 6'h2A, "R7", "older tag wins", 64'(port_tag[TW-1:0]), 64'h2A);
        check(port_data[DW-1:0] == tap_val(0, 3), "R7", "older data wins", port_data[DW-1:0], tap_val(0, 3));
        @(posedge clk); @(negedge clk);
        check_ports(4'b0000, "R7 single cycle");
        repeat (3) @(posedge clk);

        // R7: same landing cycle on different ports is not a collision
        @(negedge clk);
        issue_valid = 1; issue_op = 3'd2; issue_size = 2'd3; issue_tag = 6'h07;
        @(posedge clk); @(negedge clk); issue_valid = 0;
        @(posedge clk); @(negedge clk);
        issue_valid = 1; issue_op = 3'd3; issue_size = 2'd0; issue_tag = 6'h09;
        @(posedge clk); @(negedge clk); issue_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_ports(4'b0111, "R7 distinct ports");
        check(port_collide == 0, "R7", "no flag across ports", 64'(port_collide), 0);
        check(port_tag[2*TW +: TW] == 6'h09, "R5", "macl tag", 64'(port_tag[2*TW +: TW]), 64'h09);
        repeat (3) @(posedge clk);

        // R6: external select overrides chunk size
        @(negedge clk);
        ext_sel_en = 1; ext_sel = 8'b01_00_11_10;
        issue_valid = 1; issue_op = 3'd2; issue_size = 2'd0; issue_tag = 6'h3C;
        @(posedge clk); @(negedge clk); issue_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_ports(4'b0011, "R6 valid");
        check(port_data[DW-1:0] == tap_val(0, 2), "R6", "port0 ext sel", port_data[DW-1:0], tap_val(0, 2));
        check(port_data[DW +: DW] == tap_val(1, 3), "R6", "port1 ext sel", port_data[DW +: DW], tap_val(1, 3));
        ext_sel_en = 0;
        repeat (3) @(posedge clk);

        // R8: reset while an operation is in flight
        @(negedge clk);
        issue_valid = 1; issue_op = 3'd4; issue_size = 2'd3; issue_tag = 6'h01;
        @(posedge clk); @(negedge clk); issue_valid = 0;
        @(posedge clk); @(negedge clk); rst = 1;
        @(posedge clk); @(negedge clk); rst = 0;
        for (int k = 0; k < 6; k++) begin
            check_ports(4'b0, "R8 flush");
            @(posedge clk); @(negedge clk);
        end

        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule